// File: doc/BRIEF.md
# Oversampling Serial Receiver with Error Flags

This block turns an asynchronous serial receive line into parallel words. The line is paced by a clock-enable pulse that fires at sixteen times the bit rate on the system clock. The block waits for a falling edge on the idle-high line and confirms the start bit at its middle. It then samples each data bit at its centre and checks the stop bit the same way.

A good frame is placed in a held output register, and a ready flag is raised. The host acknowledges the word with a one-cycle read pulse. The held word stays unchanged while the next character shifts in, so the host has a full frame time to collect it.

Three sticky error flags report problems. Overrun means a new word arrived before the previous one was acknowledged. Framing means the stop bit was low although the frame carried a high data bit. All-low means the line stayed low through start, data and stop. Baud-enable generation and parity are outside this block.

Top module: `uart_rx_os`

## Requirements
- R1: While rst_n is low, word_ready, err_overrun, err_framing and err_all_low are 0 and word_out is all zeros.
- R2: Reception begins only on a sample_en pulse that sees the synchronized line low after the previous pulse saw it high. The start bit is confirmed by a low sample OVERSAMPLE/2 pulses later. If that sample is high, the block returns to idle, and word_ready, word_out and all flags are unchanged.
- R3: Data bits are sampled every OVERSAMPLE pulses after the start sample. The first data bit on the line lands in word_out bit 0 (least significant bit first).
- R4: A frame whose stop samples are all high loads word_out and sets word_ready in the clock after the last stop sample.
- R5: A one-cycle rd_ack while word_ready is high clears word_ready on the next clock and leaves word_out unchanged.
- R6: word_out keeps its value while a following frame is being received, until that frame completes well.
- R7: When a good frame completes while word_ready is high and rd_ack is low, err_overrun is set, word_out takes the new word and word_ready stays high.
- R8: A frame with a low stop sample and at least one high data bit sets err_framing. It does not set err_all_low, and it leaves word_out and word_ready unchanged.
- R9: A frame whose start, data and stop samples are all low sets err_all_low. It does not set err_framing, and it leaves word_out and word_ready unchanged.
- R10: Once set, each error flag stays set until rst_n is asserted, through later good frames and acknowledgements.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sample_en | input | 1 | One-cycle pulse at OVERSAMPLE times the bit rate |
| rxd | input | 1 | Asynchronous serial line, idle high |
| rd_ack | input | 1 | Host acknowledge of the held word |
| word_out | output | DATA_BITS | Last good received word |
| word_ready | output | 1 | A word is waiting for acknowledge |
| err_overrun | output | 1 | Sticky: unacknowledged word was replaced |
| err_framing | output | 1 | Sticky: stop bit low in a non-zero frame |
| err_all_low | output | 1 | Sticky: line low for the whole frame |

## Verification
The receive path is driven with alternating patterns (0x55, 0xA3), the extremes 0x00 and 0xFF, and single-bit words 0x01 and 0x80. The single-bit words tell a correct least-significant-first assembly from a reversed one, and tell a correct bit count from a shifted one. A start pulse shorter than half a bit separates start confirmation from plain edge triggering. A stop-low frame with high data and a fully low frame separate the framing flag from the all-low flag. A held-word frame with no acknowledge separates an overrun from a silently dropped word.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;

  typedef enum logic [1:0] {
    RX_IDLE  = 2'd0,
    RX_START = 2'd1,
    RX_DATA  = 2'd2,
    RX_STOP  = 2'd3
  } rx_state_e;

endpackage

// File: rtl/rx_line_sync.sv
module rx_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_in,
  output logic line_sync
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  generate
    if (STAGES == 1) begin : g_one
      always_comb chain_d = line_in;
    end else begin : g_many
      always_comb chain_d = {chain_q[STAGES-2:0], line_in};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '1;
    else        chain_q <= chain_d;
  end

  assign line_sync = chain_q[STAGES-1];

endmodule

// File: rtl/rx_frame_fsm.sv
module rx_frame_fsm
  import uart_rx_pkg::*;
#(
  parameter int START_BITS = 1,
  parameter int DATA_BITS  = 8,
  parameter int STOP_BITS  = 1,
  parameter int OVERSAMPLE = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 sample_en,
  input  logic                 rx_s,
  output logic                 frame_done,
  output logic                 frame_ok,
  output logic                 frame_any_high,
  output logic [DATA_BITS-1:0] frame_word
);

  localparam int TW   = (OVERSAMPLE > 2) ? $clog2(OVERSAMPLE) : 1;
  localparam int BW   = $clog2(START_BITS + DATA_BITS + STOP_BITS + 1);
  localparam int HALF = OVERSAMPLE / 2;

  rx_state_e            state_q, state_d;
  logic [TW-1:0]        tick_q, tick_d;
  logic [BW-1:0]        bitn_q, bitn_d;
  logic [DATA_BITS-1:0] shreg_q, shreg_d;
  logic                 anyhi_q, anyhi_d;
  logic                 stoplow_q, stoplow_d;
  logic                 lasthi_q, lasthi_d;
  logic                 tick_hit;
  logic                 done_c;

  always_comb begin
    if (state_q == RX_START && bitn_q == '0)
      tick_hit = sample_en && (tick_q == TW'(HALF - 1));
    else
      tick_hit = sample_en && (tick_q == TW'(OVERSAMPLE - 1));
  end

  always_comb begin
    state_d   = state_q;
    tick_d    = tick_q;
    bitn_d    = bitn_q;
    shreg_d   = shreg_q;
    anyhi_d   = anyhi_q;
    stoplow_d = stoplow_q;
    done_c    = 1'b0;
    lasthi_d  = sample_en ? rx_s : lasthi_q;
    if (state_q != RX_IDLE && sample_en && !tick_hit)
      tick_d = tick_q + TW'(1);
    unique case (state_q)
      RX_IDLE: begin
        if (sample_en && !rx_s && lasthi_q) begin
          state_d   = RX_START;
          tick_d    = '0;
          bitn_d    = '0;
          anyhi_d   = 1'b0;
          stoplow_d = 1'b0;
        end
      end
      RX_START: begin
        if (tick_hit) begin
          tick_d = '0;
          if (rx_s) begin
            state_d = RX_IDLE;
          end else if (bitn_q == BW'(START_BITS - 1)) begin
            state_d = RX_DATA;
            bitn_d  = '0;
          end else begin
            bitn_d = bitn_q + BW'(1);
          end
        end
      end
      RX_DATA: begin
        if (tick_hit) begin
          tick_d  = '0;
          anyhi_d = anyhi_q | rx_s;
          if (DATA_BITS > 1) shreg_d = {rx_s, shreg_q[DATA_BITS-1:1]};
          else               shreg_d = rx_s;
          if (bitn_q == BW'(DATA_BITS - 1)) begin
            state_d = RX_STOP;
            bitn_d  = '0;
          end else begin
            bitn_d = bitn_q + BW'(1);
          end
        end
      end
      RX_STOP: begin
        if (tick_hit) begin
          tick_d    = '0;
          stoplow_d = stoplow_q | !rx_s;
          if (bitn_q == BW'(STOP_BITS - 1)) begin
            state_d = RX_IDLE;
            done_c  = 1'b1;
          end else begin
            bitn_d = bitn_q + BW'(1);
          end
        end
      end
      default: state_d = RX_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= RX_IDLE;
      tick_q    <= '0;
      bitn_q    <= '0;
      shreg_q   <= '0;
      anyhi_q   <= 1'b0;
      stoplow_q <= 1'b0;
      lasthi_q  <= 1'b0;
    end else begin
      state_q   <= state_d;
      tick_q    <= tick_d;
      bitn_q    <= bitn_d;
      shreg_q   <= shreg_d;
      anyhi_q   <= anyhi_d;
      stoplow_q <= stoplow_d;
      lasthi_q  <= lasthi_d;
    end
  end

  assign frame_done     = done_c;
  assign frame_ok       = !(stoplow_q || !rx_s);
  assign frame_any_high = anyhi_q;
  assign frame_word     = shreg_q;

  AST_IDLE_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == RX_IDLE && !sample_en) |=> (state_q == RX_IDLE)) // R2
    else $error("receiver left idle without a sample enable");

  AST_DONE_ON_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |-> sample_en) // R3
    else $error("frame completed off a sample enable");

endmodule

// File: rtl/rx_word_hold.sv
module rx_word_hold #(
  parameter int DATA_BITS = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 frame_done,
  input  logic                 frame_ok,
  input  logic                 frame_any_high,
  input  logic [DATA_BITS-1:0] frame_word,
  input  logic                 rd_ack,
  output logic [DATA_BITS-1:0] word_out,
  output logic                 word_ready,
  output logic                 err_overrun,
  output logic                 err_framing,
  output logic                 err_all_low
);

  logic [DATA_BITS-1:0] word_q, word_d;
  logic                 ready_q, ready_d;
  logic                 ovr_q, ovr_d;
  logic                 frm_q, frm_d;
  logic                 alow_q, alow_d;
  logic                 load_good;
  logic                 load_bad;

  always_comb begin
    load_good = frame_done && frame_ok;
    load_bad  = frame_done && !frame_ok;
    word_d    = load_good ? frame_word : word_q;
    if (load_good)   ready_d = 1'b1;
    else if (rd_ack) ready_d = 1'b0;
    else             ready_d = ready_q;
    ovr_d  = ovr_q  | (load_good && ready_q && !rd_ack);
    frm_d  = frm_q  | (load_bad && frame_any_high);
    alow_d = alow_q | (load_bad && !frame_any_high);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q  <= '0;
      ready_q <= 1'b0;
      ovr_q   <= 1'b0;
      frm_q   <= 1'b0;
      alow_q  <= 1'b0;
    end else begin
      word_q  <= word_d;
      ready_q <= ready_d;
      ovr_q   <= ovr_d;
      frm_q   <= frm_d;
      alow_q  <= alow_d;
    end
  end

  assign word_out    = word_q;
  assign word_ready  = ready_q;
  assign err_overrun = ovr_q;
  assign err_framing = frm_q;
  assign err_all_low = alow_q;

  AST_ACK_CLEARS_READY: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_ack && !frame_done) |=> !word_ready) // R5
    else $error("acknowledge did not clear ready");

  AST_WORD_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_done |=> $stable(word_out)) // R6
    else $error("held word changed without a completed frame");

  AST_OVERRUN_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_done && frame_ok && word_ready && !rd_ack) |=> err_overrun) // R7
    else $error("overrun not flagged");

  AST_FLAGS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (err_overrun || err_framing || err_all_low) |=>
      ($past(err_overrun) <= err_overrun && $past(err_framing) <= err_framing &&
       $past(err_all_low) <= err_all_low)) // R10
    else $error("error flag dropped without reset");

endmodule

// File: rtl/uart_rx_os.sv
module uart_rx_os #(
  parameter int START_BITS  = 1,
  parameter int DATA_BITS   = 8,
  parameter int STOP_BITS   = 1,
  parameter int OVERSAMPLE  = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 sample_en,
  input  logic                 rxd,
  input  logic                 rd_ack,
  output logic [DATA_BITS-1:0] word_out,
  output logic                 word_ready,
  output logic                 err_overrun,
  output logic                 err_framing,
  output logic                 err_all_low
);

  logic                 rx_s;
  logic                 f_done;
  logic                 f_ok;
  logic                 f_anyhi;
  logic [DATA_BITS-1:0] f_word;

  rx_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk       (clk),
    .rst_n     (rst_n),
    .line_in   (rxd),
    .line_sync (rx_s)
  );

  rx_frame_fsm #(
    .START_BITS (START_BITS),
    .DATA_BITS  (DATA_BITS),
    .STOP_BITS  (STOP_BITS),
    .OVERSAMPLE (OVERSAMPLE)
  ) u_fsm (
    .clk            (clk),
    .rst_n          (rst_n),
    .sample_en      (sample_en),
    .rx_s           (rx_s),
    .frame_done     (f_done),
    .frame_ok       (f_ok),
    .frame_any_high (f_anyhi),
    .frame_word     (f_word)
  );

  rx_word_hold #(.DATA_BITS(DATA_BITS)) u_hold (
    .clk            (clk),
    .rst_n          (rst_n),
    .frame_done     (f_done),
    .frame_ok       (f_ok),
    .frame_any_high (f_anyhi),
    .frame_word     (f_word),
    .rd_ack         (rd_ack),
    .word_out       (word_out),
    .word_ready     (word_ready),
    .err_overrun    (err_overrun),
    .err_framing    (err_framing),
    .err_all_low    (err_all_low)
  );

endmodule

// File: tb/tb_uart_rx_os.sv
module tb_uart_rx_os;

  localparam int DW  = 8;
  localparam int EN_DIV = 4;
  localparam int BIT = 16 * EN_DIV;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          sample_en = 1'b0;
  logic          rxd = 1'b1;
  logic          rd_ack = 1'b0;
  logic [DW-1:0] word_out;
  logic          word_ready;
  logic          err_overrun, err_framing, err_all_low;

  int checks = 0;
  int errors = 0;
  bit auto_ack = 1'b0;
  bit finished = 1'b0;
  logic [DW-1:0] exp_q[$];

  always #2.5 clk = ~clk;

  uart_rx_os dut (
    .clk(clk), .rst_n(rst_n), .sample_en(sample_en), .rxd(rxd), .rd_ack(rd_ack),
    .word_out(word_out), .word_ready(word_ready), .err_overrun(err_overrun),
    .err_framing(err_framing), .err_all_low(err_all_low)
  );

  task automatic check(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    forever begin
      repeat (EN_DIV - 1) @(negedge clk);
      sample_en = 1'b1;
      @(negedge clk);
      sample_en = 1'b0;
    end
  end

  initial begin
    repeat (100000) @(negedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  // monitor: pops the scoreboard whenever a word is offered and acknowledges it
  initial begin
    forever begin
      @(negedge clk);
      if (auto_ack && word_ready) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R2 unexpected word", {8'h0, word_out}, 16'h0);
        end else begin
          logic [DW-1:0] e;
          e = exp_q.pop_front();
          check(word_out == e, "R3 R4 received word", {8'h0, word_out}, {8'h0, e});
        end
        rd_ack = 1'b1;
        @(negedge clk);
        rd_ack = 1'b0;
        check(word_ready == 1'b0, "R5 ack clears ready", {15'h0, word_ready}, 16'h0);
      end
    end
  end

  task automatic drive_bit(input logic v);
    rxd = v;
    repeat (BIT) @(negedge clk);
  endtask

  task automatic send_frame(input logic [DW-1:0] d, input logic stop_v);
    drive_bit(1'b0);
    for (int i = 0; i < DW; i++) drive_bit(d[i]);
    drive_bit(stop_v);
    rxd = 1'b1;
    repeat (BIT) @(negedge clk);
  endtask

  task automatic pulse_ack();
    rd_ack = 1'b1;
    @(negedge clk);
    rd_ack = 1'b0;
  endtask

  initial begin
    logic [DW-1:0] pats[6];
    pats = '{8'h55, 8'hA3, 8'h00, 8'hFF, 8'h01, 8'h80};
    repeat (5) @(negedge clk);
    check(word_ready == 0 && word_out == 0, "R1 reset ready/word", {7'h0, word_ready, word_out}, 16'h0);
    check({err_overrun, err_framing, err_all_low} == 3'b000, "R1 reset flags",
          {13'h0, err_overrun, err_framing, err_all_low}, 16'h0);
    rst_n = 1'b1;
    repeat (100) @(negedge clk);

    // main function through the scoreboard, LSB first
    auto_ack = 1'b1;
    foreach (pats[i]) begin
      exp_q.push_back(pats[i]);
      send_frame(pats[i], 1'b1);
    end
    repeat (50) @(negedge clk);
    check(exp_q.size() == 0, "R4 all words delivered", exp_q.size(), 16'h0);

    // short low glitch: start not confirmed
    rxd = 1'b0;
    repeat (3 * EN_DIV) @(negedge clk);
    rxd = 1'b1;
    repeat (4 * BIT) @(negedge clk);
    check(word_ready == 0, "R2 glitch gives no word", {15'h0, word_ready}, 16'h0);
    check({err_overrun, err_framing, err_all_low} == 3'b000, "R2 glitch gives no flag",
          {13'h0, err_overrun, err_framing, err_all_low}, 16'h0);
    check(word_out == 8'h80, "R2 glitch keeps word", {8'h0, word_out}, 16'h0080);
    exp_q.push_back(8'h3C);
    send_frame(8'h3C, 1'b1);
    repeat (20) @(negedge clk);
    check(exp_q.size() == 0, "R2 frame after glitch", exp_q.size(), 16'h0);

    // hold behaviour with manual acknowledge
    auto_ack = 1'b0;
    send_frame(8'hC6, 1'b1);
    check(word_ready == 1 && word_out == 8'hC6, "R4 ready with word",
          {7'h0, word_ready, word_out}, 16'h01C6);
    pulse_ack();
    check(word_ready == 0 && word_out == 8'hC6, "R5 ack keeps word",
          {7'h0, word_ready, word_out}, 16'h00C6);
    drive_bit(1'b0);
    for (int i = 0; i < 5; i++) drive_bit(1'(8'h39 >> i));
    check(word_out == 8'hC6 && word_ready == 0, "R6 word held during next frame",
          {7'h0, word_ready, word_out}, 16'h00C6);
    for (int i = 5; i < DW; i++) drive_bit(1'(8'h39 >> i));
    drive_bit(1'b1);
    repeat (BIT) @(negedge clk);
    check(word_out == 8'h39 && word_ready == 1 && err_overrun == 0, "R4 second word",
          {6'h0, err_overrun, word_ready, word_out}, 16'h0139);

    // overrun: no acknowledge before the next word
    send_frame(8'h5A, 1'b1);
    check(err_overrun == 1, "R7 overrun set", {15'h0, err_overrun}, 16'h1);
    check(word_out == 8'h5A && word_ready == 1, "R7 word replaced",
          {7'h0, word_ready, word_out}, 16'h015A);
    pulse_ack();

    // framing: stop low with high data
    send_frame(8'h3C, 1'b0);
    check(err_framing == 1 && err_all_low == 0, "R8 framing only",
          {14'h0, err_framing, err_all_low}, 16'h2);
    check(word_out == 8'h5A && word_ready == 0, "R8 word and ready untouched",
          {7'h0, word_ready, word_out}, 16'h005A);

    // all-low frame
    send_frame(8'h00, 1'b0);
    check(err_all_low == 1, "R9 all-low set", {15'h0, err_all_low}, 16'h1);
    check(word_out == 8'h5A && word_ready == 0, "R9 word and ready untouched",
          {7'h0, word_ready, word_out}, 16'h005A);

    // sticky through a good frame and its acknowledge
    send_frame(8'h77, 1'b1);
    pulse_ack();
    check({err_overrun, err_framing, err_all_low} == 3'b111, "R10 flags sticky",
          {13'h0, err_overrun, err_framing, err_all_low}, 16'h7);
    check(word_out == 8'h77, "R4 good frame after errors", {8'h0, word_out}, 16'h0077);

    rst_n = 1'b0;
    @(negedge clk);
    check({err_overrun, err_framing, err_all_low} == 3'b000 && word_out == 0,
          "R1 R10 reset clears", {5'h0, err_overrun, err_framing, err_all_low, word_out}, 16'h0);
    rst_n = 1'b1;
    repeat (10) @(negedge clk);
    finish_run();
  end

endmodule